// File: doc/BRIEF.md
# Ones-Count Microsequencer

This controller steps a register-file datapath through a bit-counting program. On a start pulse it loads a word from the datapath's input port into a data register, clears a count register and sets a mask register to one. It then loops three micro-steps: AND the data with the mask into a scratch register, add the scratch value into the count, and shift the data right by one. It finishes by placing the count on the datapath's output port. The controller sees the datapath only through a single status input that reports whether the data register is zero, and it drives only a 20-bit control word and a completion flag.

The loop test follows each shift, and the same test is also made before the first pass, so a zero input goes straight to the output step. Constants are produced without a literal path: zero comes from adding two disabled read ports, and one from incrementing a disabled read port. A run for an input whose highest set bit sits at position k-1 takes 4 + 4k cycles from the first step to the output step.

Top module: `ones_count_seq`

## Requirements
- R1: Control word layout: bit 19 input enable (write data comes from the input port), bit 18 output enable, bits 17:15 ALU operation (000 AND, 100 add, 110 increment A), bits 14:12 shift operation (000 pass, 001 right by one), bit 11 write enable, bits 10:8 write address, bit 7 read-A enable, bits 6:4 read-A address, bit 3 read-B enable, bits 2:0 read-B address; a disabled read port supplies zero. Registers: 1 data, 2 mask, 3 count, 4 scratch.
- R2: While reset is low, and in every idle cycle, the control word is all zeros and done is low; a reset during a run returns the controller to idle.
- R3: A start seen while idle makes the next three words: load register 1 from the input (input enable, pass, write 1); clear register 3 (add, both reads disabled, write 3); set register 2 (increment, read A disabled, write 2).
- R4: In the mask-setting cycle the zero status is tested: if high the next word is the output step, otherwise the AND step.
- R5: The loop body is AND of registers 1 and 2 into 4; add of 3 and 4 into 3; add of register 1 with read B disabled, shifted right, into 1; then one all-zero test word, after which the output step follows if the zero status is high and the AND step otherwise.
- R6: The output step reads register 3 on port A with port B disabled, adds, passes, sets output enable and writes nothing; done is high in that cycle only, and the following cycle is idle.
- R7: A start seen while a run is in progress, including during the output step, has no effect.
- R8: With the datapath attached, the output port in the output step equals the number of 1 bits in the input word, for zero, all-ones and arbitrary words.
- R9: A run lasts 4 + 4k cycles from the load step to the output step inclusive, where k is the bit length of the input word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| data_zero | input | 1 | High when the datapath's data register is zero |
| ctrl_word | output | 20 | Control word driven to the datapath |
| done | output | 1 | High during the output step |

## Verification
The sharpest collision is a start request arriving in the same cycle as the output step, where the controller must finish and fall idle instead of chaining into a new load; the bench holds start high across a whole run, including that cycle, and expects one idle cycle of all-zero word after done. The other is the zero decision coinciding with the mask setup, provoked with a zero input, where the output step must follow the mask step directly. Every cycle's word is compared against a queue-based model that predicts the sequence from the input word's bit length.

// File: rtl/ones_count_seq.sv
module ones_count_seq #(
  parameter int AW  = 3,
  parameter int OPW = 3,
  parameter logic [AW-1:0] R_DATA = 1,
  parameter logic [AW-1:0] R_MASK = 2,
  parameter logic [AW-1:0] R_CNT  = 3,
  parameter logic [AW-1:0] R_TMP  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       data_zero,
  output logic [2+2*OPW+3*(AW+1)-1:0] ctrl_word,
  output logic                       done
);
  localparam int CW     = 2 + 2*OPW + 3*(AW+1);
  localparam int IE_BIT = CW - 1;
  localparam int OE_BIT = CW - 2;
  localparam int WE_BIT = 2*(AW+1) + AW;

  localparam logic [OPW-1:0] ALU_AND = OPW'(0);
  localparam logic [OPW-1:0] ALU_ADD = OPW'(4);
  localparam logic [OPW-1:0] ALU_INC = OPW'(6);
  localparam logic [OPW-1:0] SH_PASS = OPW'(0);
  localparam logic [OPW-1:0] SH_SHR  = OPW'(1);
  localparam logic [AW-1:0]  R_NONE  = '0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LOAD, ST_CLR, ST_MASK, ST_AND, ST_ACC, ST_SHR, ST_CHK, ST_EMIT
  } state_t;

  state_t state, state_nx;

  function automatic logic [CW-1:0] mk(
    input logic ie, input logic oe,
    input logic [OPW-1:0] alu, input logic [OPW-1:0] sh,
    input logic we, input logic [AW-1:0] wa,
    input logic ea, input logic [AW-1:0] aa,
    input logic eb, input logic [AW-1:0] ba);
    return {ie, oe, alu, sh, we, wa, ea, aa, eb, ba};
  endfunction

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (start) state_nx = ST_LOAD;
      ST_LOAD: state_nx = ST_CLR;
      ST_CLR:  state_nx = ST_MASK;
      ST_MASK: state_nx = data_zero ? ST_EMIT : ST_AND;
      ST_AND:  state_nx = ST_ACC;
      ST_ACC:  state_nx = ST_SHR;
      ST_SHR:  state_nx = ST_CHK;
      ST_CHK:  state_nx = data_zero ? ST_EMIT : ST_AND;
      ST_EMIT: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_comb begin
    case (state)
      ST_LOAD: ctrl_word = mk(1'b1, 1'b0, ALU_AND, SH_PASS, 1'b1, R_DATA, 1'b0, R_NONE, 1'b0, R_NONE);
      ST_CLR:  ctrl_word = mk(1'b0, 1'b0, ALU_ADD, SH_PASS, 1'b1, R_CNT,  1'b0, R_NONE, 1'b0, R_NONE);
      ST_MASK: ctrl_word = mk(1'b0, 1'b0, ALU_INC, SH_PASS, 1'b1, R_MASK, 1'b0, R_NONE, 1'b0, R_NONE);
      ST_AND:  ctrl_word = mk(1'b0, 1'b0, ALU_AND, SH_PASS, 1'b1, R_TMP,  1'b1, R_DATA, 1'b1, R_MASK);
      ST_ACC:  ctrl_word = mk(1'b0, 1'b0, ALU_ADD, SH_PASS, 1'b1, R_CNT,  1'b1, R_CNT,  1'b1, R_TMP);
      ST_SHR:  ctrl_word = mk(1'b0, 1'b0, ALU_ADD, SH_SHR,  1'b1, R_DATA, 1'b1, R_DATA, 1'b0, R_NONE);
      ST_EMIT: ctrl_word = mk(1'b0, 1'b1, ALU_ADD, SH_PASS, 1'b0, R_NONE, 1'b1, R_CNT,  1'b0, R_NONE);
      default: ctrl_word = '0;
    endcase
  end

  assign done = (state == ST_EMIT);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ctrl_word == '0));

  assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start) |=> (ctrl_word[IE_BIT] && ctrl_word[WE_BIT]));

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && start) |=> !ctrl_word[IE_BIT]);

  assert_pretest_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MASK && data_zero) |=> done);

  assert_shift_then_test_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHR) |=> (ctrl_word == '0 && !done));

  assert_loop_reentry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHK && !data_zero) |=> (!done && ctrl_word[WE_BIT] && !ctrl_word[OE_BIT]));

  assert_emit_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ctrl_word[OE_BIT] && !ctrl_word[WE_BIT]));
endmodule

// File: tb/ones_count_seq_test.sv
module ones_count_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] inport = '0;
  logic [19:0] cw;
  logic done;
  logic dzero;

  int n_chk = 0;
  int n_bad = 0;
  bit seen_done;
  int cyc_after_start;
  bit over = 0;

  always #2 clk = ~clk;

  ones_count_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .data_zero(dzero),
    .ctrl_word(cw), .done(done)
  );

  // Behavioural datapath driven by the control word (R1 layout)
  logic [15:0] rf [8] = '{default: 16'h0};
  logic [15:0] opa, opb, alu, shf, wdat, outport;
  always_comb begin
    opa = cw[7] ? rf[cw[6:4]] : 16'h0;
    opb = cw[3] ? rf[cw[2:0]] : 16'h0;
    case (cw[17:15])
      3'b000:  alu = opa & opb;
      3'b100:  alu = opa + opb;
      3'b110:  alu = opa + 16'd1;
      default: alu = 16'h0;
    endcase
    shf = (cw[14:12] == 3'b001) ? (alu >> 1) : alu;
    wdat = cw[19] ? inport : shf;
    outport = cw[18] ? shf : 16'h0;
  end
  assign dzero = (rf[1] == 16'h0);
  always @(posedge clk) if (cw[11]) rf[cw[10:8]] <= wdat;

  function automatic logic [19:0] w(input bit ie, input bit oe, input logic [2:0] op,
      input logic [2:0] sh, input bit we, input logic [2:0] wa, input bit ea,
      input logic [2:0] aa, input bit eb, input logic [2:0] ba);
    return {ie, oe, op, sh, we, wa, ea, aa, eb, ba};
  endfunction

  logic [19:0] W_LOAD, W_CLR, W_MASK, W_AND, W_ACC, W_SHR, W_EMIT;
  initial begin
    W_LOAD = w(1, 0, 3'b000, 3'b000, 1, 3'd1, 0, 3'd0, 0, 3'd0);
    W_CLR  = w(0, 0, 3'b100, 3'b000, 1, 3'd3, 0, 3'd0, 0, 3'd0);
    W_MASK = w(0, 0, 3'b110, 3'b000, 1, 3'd2, 0, 3'd0, 0, 3'd0);
    W_AND  = w(0, 0, 3'b000, 3'b000, 1, 3'd4, 1, 3'd1, 1, 3'd2);
    W_ACC  = w(0, 0, 3'b100, 3'b000, 1, 3'd3, 1, 3'd3, 1, 3'd4);
    W_SHR  = w(0, 0, 3'b100, 3'b001, 1, 3'd1, 1, 3'd1, 0, 3'd0);
    W_EMIT = w(0, 1, 3'b100, 3'b000, 0, 3'd0, 1, 3'd3, 0, 3'd0);
  end

  logic [19:0] q [$];

  function automatic int bitlen(input logic [15:0] v);
    int k = 0;
    while (v != 0) begin k++; v = v >> 1; end
    return k;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_run(input logic [15:0] d);
    q.push_back(W_LOAD); q.push_back(W_CLR); q.push_back(W_MASK);
    for (int i = 0; i < bitlen(d); i++) begin
      q.push_back(W_AND); q.push_back(W_ACC); q.push_back(W_SHR); q.push_back(20'h0);
    end
    q.push_back(W_EMIT);
  endtask

  task automatic tick(input bit st);
    logic [19:0] exp;
    bit busy;
    string tag;
    @(negedge clk);
    if (!rst_n) q.delete();
    busy = (q.size() != 0);
    exp = busy ? q[0] : 20'h0;
    if (!busy) tag = "R2";
    else if (exp == W_LOAD || exp == W_CLR || exp == W_MASK) tag = "R3";
    else if (exp == W_EMIT) tag = "R6";
    else tag = "R5";
    check(cw == exp, tag, 32'(cw), 32'(exp));
    check(done == (busy && exp == W_EMIT), "R6", 32'(done), 32'(busy && exp == W_EMIT));
    if (busy && exp == W_EMIT) begin
      seen_done = 1;
      check(cw[18] && !cw[11], "R1", 32'(cw), 32'(W_EMIT));
      check(outport == 16'($countones(inport)), "R8", 32'(outport), 32'($countones(inport)));
    end
    if (busy) begin void'(q.pop_front()); cyc_after_start++; end
    start = st;
    if (st && !busy && rst_n) begin push_run(inport); cyc_after_start = 0; end
  endtask

  task automatic run(input logic [15:0] d, input bit busy_start, input string tag);
    int lim = 0;
    inport = d;
    seen_done = 0;
    tick(1);
    while (!seen_done && lim < 200) begin tick(busy_start); lim++; end
    check(cyc_after_start == 4 + 4*bitlen(d), tag, 32'(cyc_after_start), 32'(4 + 4*bitlen(d)));
    tick(0);
  endtask

  initial begin
    rst_n = 0;
    for (int i = 0; i < 3; i++) tick(0);
    rst_n = 1;
    for (int i = 0; i < 2; i++) tick(0);
    run(16'h0000, 0, "R4");
    run(16'hFFFF, 0, "R9");
    run(16'h0001, 0, "R9");
    run(16'h8000, 0, "R9");
    run(16'hA5C3, 1, "R7");
    for (int i = 0; i < 8; i++) run(16'($urandom), 0, "R9");
    run(16'h0000, 1, "R7");
    inport = 16'h00F0;
    tick(1);
    for (int i = 0; i < 6; i++) tick(0);
    rst_n = 0;
    tick(0);
    rst_n = 1;
    for (int i = 0; i < 3; i++) tick(0);
    run(16'h7FFE, 0, "R8");
    over = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!over) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule